// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block keeps the 64-bit base register that places the memory-mapped PCIe configuration window in the system address map. It turns the stored value into three things: a window enable, a window base aligned to the selected size, and a window length in bytes. It checks any 64-bit memory address presented to it against that window and raises a hit flag in the same cycle. It also reports where the 32-bit PCI memory hole starts, because that hole begins just above the configuration window.

Software writes the register through a byte-enabled port. Every write is taken in the cycle it is presented, so the port has no handshake. The decoded outputs and the read-back value change at the clock edge that stores the write. A reset loads a parameterised default base with the window disabled. Producing configuration transactions from a hit, and routing them by bus, device and function, are left to other blocks.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the register reads back `RST_BASE`, which means enable clear and size code 00. `win_en` is 0, `win_hit` is 0 and `hole_start` equals `RST_BASE`.
- R2: When `wr_en` is high, each byte lane i with `wr_be[i]` set loads `wr_data[8i+7:8i]` at the clock edge. `rd_data` returns the stored value, with every bit outside bit 0, bits 2:1 and bits 35:26 reading as zero.
- R3: Register bit 0 is the window enable. While `win_en` is 0, `win_hit` is 0 for every address.
- R4: Register bits 2:1 select the size. Code 00 gives a 256 MiB window with base bits 35:28. Code 01 gives 128 MiB with base bits 35:27. Code 10 gives 64 MiB with base bits 35:26. All lower base bits read as zero in `win_base`.
- R5: Size code 11 is reserved. It forces `win_en` to 0 and `win_len` to 0, sets `win_base` to 0, and no address hits.
- R6: `hole_start` equals `win_base + win_len` while `win_en` is 1, and equals `RST_BASE` while `win_en` is 0.
- R7: `win_hit` is 1 exactly when `win_en` is 1 and `win_base <= chk_addr < win_base + win_len`. It is combinational in `chk_addr`.
- R8: A cycle in which `wr_en` is low or `wr_be` is all zero leaves `rd_data` and every decoded output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 8 | Byte enables for the write |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Stored register value, unimplemented bits zero |
| chk_addr | input | 64 | Memory address compared against the window |
| win_hit | output | 1 | Address falls inside the enabled window |
| win_en | output | 1 | Window enabled (after reserved-code gating) |
| win_base | output | 64 | Size-aligned window base |
| win_len | output | 64 | Window length in bytes, 0 when reserved |
| hole_start | output | 64 | Start of the 32-bit PCI memory hole |

## Verification
The bench probes the addresses one below the base, the base itself, the last byte of the window and the first byte past its end. This is done for each of the three sizes. A comparator using `<=` at the top end would hit one byte too far, and a wrong size mask would move the base. The bench sets the low base bits 27:26 while the size is 256 MiB. A decoder that skipped masking by size would then report an unaligned base and move the hole start. It also writes the reserved size code with the enable bit set, which catches a design that still opens a window. Writes with all byte enables clear, and single-lane writes, catch lanes that are tied together or a store that ignores the byte strobes.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  typedef enum logic [1:0] {
    WSZ_256M = 2'b00,
    WSZ_128M = 2'b01,
    WSZ_64M  = 2'b10,
    WSZ_RSVD = 2'b11
  } win_size_e;

  localparam int unsigned EN_POS   = 0;
  localparam int unsigned SIZE_LSB = 1;
  localparam int unsigned SIZE_W   = 2;
  localparam int unsigned SIZE_STEPS = 3;

endpackage

// File: rtl/cfgwin_regfile.sv
module cfgwin_regfile #(
  parameter int unsigned DW       = 64,
  parameter logic [DW-1:0] IMPL   = '1,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DW/8-1:0]     wr_be,
  input  logic [DW-1:0]       wr_data,
  output logic [DW-1:0]       reg_q
);
  localparam int unsigned NB = DW / 8;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [7:0] LANE_IMPL = IMPL[8*i +: 8];
    localparam logic [7:0] LANE_RST  = RST_VAL[8*i +: 8] & LANE_IMPL;
    logic [7:0] lane_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lane_q <= LANE_RST;
      end else if (wr_en && wr_be[i]) begin
        lane_q <= wr_data[8*i +: 8] & LANE_IMPL;
      end
    end

    assign reg_q[8*i +: 8] = lane_q;
  end
endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
#(
  parameter int unsigned AW        = 64,
  parameter int unsigned BASE_HI   = 35,
  parameter int unsigned MAX_SHIFT = 28
) (
  input  logic [AW-1:0] reg_q,
  output logic          win_en,
  output logic [AW-1:0] win_base,
  output logic [AW-1:0] win_len
);
  win_size_e    code;
  logic         valid;
  int           sh;
  logic [AW-1:0] mask;

  assign code = win_size_e'(reg_q[SIZE_LSB +: SIZE_W]);

  always_comb begin
    valid = 1'b1;
    sh    = MAX_SHIFT;
    unique case (code)
      WSZ_256M: sh = MAX_SHIFT;
      WSZ_128M: sh = MAX_SHIFT - 1;
      WSZ_64M:  sh = MAX_SHIFT - 2;
      default: begin
        valid = 1'b0;
        sh    = MAX_SHIFT;
      end
    endcase
  end

  always_comb begin
    for (int b = 0; b < AW; b++) begin
      mask[b] = (b >= sh) && (b <= BASE_HI);
    end
  end

  assign win_en   = valid && reg_q[EN_POS];
  assign win_base = valid ? (reg_q & mask) : '0;
  assign win_len  = valid ? (AW'(1) << sh) : '0;
endmodule

// File: rtl/cfgwin_cmp.sv
module cfgwin_cmp #(
  parameter int unsigned AW = 64
) (
  input  logic [AW-1:0] addr,
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic          hit
);
  logic [AW-1:0] limit;
  logic          above_lo;
  logic          below_hi;

  assign limit    = base + len;
  assign above_lo = (addr >= base);
  assign below_hi = (addr < limit);
  assign hit      = en && above_lo && below_hi;
endmodule

// File: rtl/cfgwin_hole.sv
module cfgwin_hole #(
  parameter int unsigned    AW       = 64,
  parameter logic [AW-1:0]  DFLT     = '0
) (
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] hole
);
  assign hole = en ? (base + len) : DFLT;
endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder #(
  parameter int unsigned   ADDR_W    = 64,
  parameter int unsigned   BASE_HI   = 35,
  parameter int unsigned   MAX_SHIFT = 28,
  parameter logic [63:0]   RST_BASE  = 64'h0000_0000_B000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W/8-1:0] wr_be,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              win_hit,
  output logic              win_en,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_len,
  output logic [ADDR_W-1:0] hole_start
);
  import cfgwin_pkg::*;

  localparam int unsigned MIN_SHIFT = MAX_SHIFT - (SIZE_STEPS - 1);

  function automatic logic [ADDR_W-1:0] impl_bits();
    logic [ADDR_W-1:0] m;
    m = '0;
    m[EN_POS] = 1'b1;
    for (int b = 0; b < int'(SIZE_W); b++) m[SIZE_LSB + b] = 1'b1;
    for (int b = MIN_SHIFT; b <= int'(BASE_HI); b++) m[b] = 1'b1;
    return m;
  endfunction

  localparam logic [ADDR_W-1:0] IMPL    = impl_bits();
  localparam logic [ADDR_W-1:0] RST_VAL = ADDR_W'(RST_BASE);

  logic [ADDR_W-1:0] reg_q;

  cfgwin_regfile #(
    .DW(ADDR_W), .IMPL(IMPL), .RST_VAL(RST_VAL)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .reg_q(reg_q)
  );

  cfgwin_decode #(
    .AW(ADDR_W), .BASE_HI(BASE_HI), .MAX_SHIFT(MAX_SHIFT)
  ) u_dec (
    .reg_q(reg_q), .win_en(win_en), .win_base(win_base), .win_len(win_len)
  );

  cfgwin_cmp #(.AW(ADDR_W)) u_cmp (
    .addr(chk_addr), .en(win_en), .base(win_base), .len(win_len), .hit(win_hit)
  );

  cfgwin_hole #(.AW(ADDR_W), .DFLT(RST_VAL)) u_hole (
    .en(win_en), .base(win_base), .len(win_len), .hole(hole_start)
  );

  assign rd_data = reg_q;
endmodule

// File: rtl/cfgwin_decoder_chk.sv
module cfgwin_decoder_chk #(
  parameter int unsigned ADDR_W   = 64,
  parameter logic [63:0] RST_BASE = 64'h0000_0000_B000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W/8-1:0] wr_be,
  input logic [ADDR_W-1:0] rd_data,
  input logic [ADDR_W-1:0] chk_addr,
  input logic              win_hit,
  input logic              win_en,
  input logic [ADDR_W-1:0] win_base,
  input logic [ADDR_W-1:0] win_len,
  input logic [ADDR_W-1:0] hole_start
);
  // R1
  p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data == ADDR_W'(RST_BASE)) && !win_en);

  p_off_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> !win_hit);

  p_base_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_len != '0) |-> ((win_base & (win_len - 1'b1)) == '0));

  p_reserved_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2:1] == 2'b11) |-> (!win_en && (win_len == '0)));

  p_hole_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> (hole_start == ADDR_W'(RST_BASE)));

  p_hole_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_en |-> (hole_start == win_base + win_len));

  p_hit_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> ((chk_addr >= win_base) && (chk_addr < win_base + win_len)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (|wr_be)) |=> ($stable(rd_data) && $stable(win_base) && $stable(win_len)));
endmodule

bind cfgwin_decoder cfgwin_decoder_chk #(
  .ADDR_W(ADDR_W), .RST_BASE(RST_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .rd_data(rd_data),
  .chk_addr(chk_addr), .win_hit(win_hit), .win_en(win_en), .win_base(win_base),
  .win_len(win_len), .hole_start(hole_start)
);

// File: tb/cfgwin_decoder_tb_top.sv
module cfgwin_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] RST_B = 64'h0000_0000_B000_0000;
  localparam logic [63:0] IMPL  = 64'h0000_000F_FC00_0007;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_be = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] chk_addr = '0;
  logic [63:0] rd_data, win_base, win_len, hole_start;
  logic        win_hit, win_en;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [63:0] mreg;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgwin_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .chk_addr(chk_addr), .win_hit(win_hit), .win_en(win_en),
    .win_base(win_base), .win_len(win_len), .hole_start(hole_start)
  );

  // behavioural reference register
  always @(posedge clk) begin
    if (!rst_n) mreg <= RST_B;
    else if (wr_en) begin
      for (int i = 0; i < 8; i++)
        if (wr_be[i]) mreg[8*i +: 8] <= wr_data[8*i +: 8] & IMPL[8*i +: 8];
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic expect_now(output logic e_en, output logic [63:0] e_base,
                            output logic [63:0] e_len, output logic [63:0] e_hole,
                            output logic e_hit);
    int code;
    int sh;
    logic [63:0] msk;
    code = int'(mreg[2:1]);
    if (code == 3) begin
      e_en = 0; e_base = 0; e_len = 0;
    end else begin
      sh = 28 - code;
      msk = ((64'd1 << 36) - 1) & ~((64'd1 << sh) - 1);
      e_len = 64'd1 << sh;
      e_base = mreg & msk;
      e_en = mreg[0];
    end
    e_hole = e_en ? e_base + e_len : RST_B;
    e_hit = e_en && (chk_addr >= e_base) && (chk_addr < e_base + e_len);
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic ee, eh;
    logic [63:0] eb, el, eho;
    if (rst_n) begin
      expect_now(ee, eb, el, eho, eh);
      chk("R2 rd_data", rd_data, mreg);
      chk("R3 win_en", {63'd0, win_en}, {63'd0, ee});
      chk("R4 win_base", win_base, eb);
      chk("R4 win_len", win_len, el);
      chk("R6 hole_start", hole_start, eho);
      chk("R7 win_hit", {63'd0, win_hit}, {63'd0, eh});
    end
  end

  task automatic wr(input logic [7:0] be, input logic [63:0] d);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic probe(input logic [63:0] a);
    chk_addr = a;
    @(posedge clk); #1;
  endtask

  task automatic edges(input logic [63:0] b, input logic [63:0] l);
    probe(b - 1); probe(b); probe(b + l - 1); probe(b + l);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp<=100000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] snap;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, RST_B);
    chk("R1 win_en", {63'd0, win_en}, 64'd0);
    chk("R1 hole_start", hole_start, RST_B);
    @(posedge clk); #1;
    probe(RST_B);                      // R3 disabled: no hit
    wr(8'hFF, 64'h0000_0000_E000_0001); // R4 256 MiB enabled
    edges(64'hE000_0000, 64'h1000_0000);
    wr(8'hFF, 64'h0000_0000_EC00_0001); // R4 low bits masked at 256 MiB
    edges(64'hE000_0000, 64'h1000_0000);
    wr(8'hFF, 64'h0000_0000_E800_0003); // R4 128 MiB
    edges(64'hE800_0000, 64'h0800_0000);
    wr(8'hFF, 64'h0000_0000_EC00_0005); // R4 64 MiB
    edges(64'hEC00_0000, 64'h0400_0000);
    wr(8'hFF, 64'h0000_0000_E000_0007); // R5 reserved
    probe(64'hE000_0000);
    @(negedge clk);
    chk("R5 win_en", {63'd0, win_en}, 64'd0);
    chk("R5 win_len", win_len, 64'd0);
    chk("R5 win_hit", {63'd0, win_hit}, 64'd0);
    @(posedge clk); #1;
    wr(8'hFF, 64'hFFFF_FFFF_FFFF_FFFF); // R2 unimplemented bits read zero
    wr(8'hFF, 64'h0000_0000_D000_0001);
    snap = rd_data;
    wr(8'h00, 64'h0000_0000_1000_0006); // R8 no byte enables
    wr_en = 1'b0; wr_be = 8'hFF; wr_data = '0; // R8 strobe low
    @(posedge clk); #1; wr_be = '0;
    @(negedge clk);
    chk("R8 rd_data held", rd_data, snap);
    @(posedge clk); #1;
    wr(8'h01, 64'h0000_0000_0000_0002); // R2 lane 0 only
    wr(8'h10, 64'h0000_0003_0000_0000); // R2 lane 4 only
    wr(8'h01, 64'h0000_0000_0000_0001);
    edges(64'h0000_0003_D000_0000, 64'h1000_0000);
    for (int n = 0; n < 400; n++) begin
      wr($urandom(), {$urandom(), $urandom()} & 64'h0000_000F_FFFF_FFFF);
      if ($urandom_range(0, 1) == 1) edges(win_base, win_len);
      else probe({$urandom(), $urandom()} & 64'h0000_000F_FFFF_FFFF);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule